// File: doc/BRIEF.md
# Single-Level GPU Address Translator

This block sits between a set of GPU memory clients and the memory system and turns each client's virtual address into a physical one. Translation uses one flat table in system memory, with one 32-bit entry per 4 KB page. Entry 0 describes the page at virtual address 0x0100_0000. A small fully associative cache of recent entries serves repeated accesses without touching memory. On a cache miss the block issues one read to the table and stalls new requests until the entry returns.

Each response carries either the translated physical address or, when the access fails, a programmable error address and a fault flag. An access fails when its address is out of range, when its entry is empty, when it lacks the permission it needs, or when the resulting physical page is outside a protection window. The first fault is recorded with its virtual address and client number and stays until it is cleared. An interrupt output reports the recorded fault when its mask bit is set.

The control state machine has three states. IDLE accepts requests and answers hits, bypasses and range faults directly. The *miss* transition goes from IDLE to FETCH, where the table read is issued. The *issue* transition goes from FETCH to WAIT, where the block waits for the entry. The *return* transition goes from WAIT back to IDLE and delivers the response.

Top module: `gpu_addr_xlate`

## Requirements
- R1: Bypass. A request passes through untranslated (physical = virtual, no table read, response one cycle after acceptance) in two cases: global enable (register 0 bit 0) is clear, or the client's translate bit (register 0 bit 8+client) is clear.
- R2: For a translated request, a virtual address below 0x0100_0000 is a fault and is answered one cycle after acceptance with no table read. So is an address at or above 0x0100_0000 + regions·64 KB, where regions is register 1 bits [11:0] (reset 0xfff).
- R3: On a miss the block issues exactly one single-cycle table read at table_base (register 2) + 4·((VA − 0x0100_0000) >> 12). While that read is outstanding, req_ready stays low. The response appears one cycle after mem_rvalid, which is three cycles after acceptance with a memory that answers in one cycle.
- R4: A translated physical address is entry[31:12] joined with VA[11:0]. Entry bit 0 grants write and bit 1 grants read. An access without the permission it needs is a fault.
- R5: An all-zero entry is a fault and is never cached, so a repeat access reads the table again.
- R6: An access that hits one of the 4 cached entries is answered one cycle after acceptance, with no table read.
- R7: Cache fills replace entries in round-robin order, starting from entry 0 after reset.
- R8: Writing 1 to register 7 bit 0 discards every cached entry. An entry whose table read is in flight at that moment is not cached.
- R9: A faulting response sets rsp_fault and returns the error address (register 3) with bits [4:0] forced to zero.
- R10: A resulting physical page outside [register 4, register 5] (compared on bits [31:12]) is a fault. The reset values of these registers are 0x0000_0000 and 0xffff_f000.
- R11: The first fault latches its VA and client number on fault_va / fault_client. Later faults do not overwrite them until register 6 is written with bit 1 set, which clears the record.
- R12: irq is high exactly when a fault record is held and the mask (register 6 bit 0) is set.
- R13: After reset req_ready is high, and rsp_valid, mem_req, irq and fault_va are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word select |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_client | input | CLW | Requesting client number |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | Response strobe |
| rsp_pa | output | 32 | Physical or error address |
| rsp_fault | output | 1 | Access faulted and was redirected |
| mem_req | output | 1 | Table read request (one cycle) |
| mem_addr | output | 32 | Table entry address |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 32 | Table entry |
| irq | output | 1 | Masked fault interrupt |
| fault_va | output | 32 | Recorded faulting VA |
| fault_client | output | CLW | Recorded faulting client |

## Verification
Hits, bypasses and range faults answer on the cycle after the accepting edge. A miss shows mem_req on the following cycle and answers one cycle after the table data arrives. The bench's memory returns data one cycle after the request, so a miss answers three cycles after acceptance. The bench drives on falling edges and counts falling edges from the accepting edge up to the first one with rsp_valid high, then compares that count against 1 or 3 for each vector. Register effects such as the interrupt output are sampled on the falling edge right after the write's rising edge. The fetch count and the last table address are compared per access, so an extra or missing table read is caught.

// File: rtl/gax_pkg.sv
package gax_pkg;
    localparam int          ADDR_W       = 32;
    localparam int          PAGE_SHIFT   = 12;
    localparam int          REGION_SHIFT = 16;
    localparam int          ERR_ALIGN    = 5;
    localparam int          VPN_W        = ADDR_W - PAGE_SHIFT;
    localparam int          RGN_W        = 12;
    localparam logic [ADDR_W-1:0] VA_BASE = 32'h0100_0000;

    // register word map
    localparam logic [2:0] REG_CTRL    = 3'd0;
    localparam logic [2:0] REG_REGIONS = 3'd1;
    localparam logic [2:0] REG_PTBASE  = 3'd2;
    localparam logic [2:0] REG_ERRADDR = 3'd3;
    localparam logic [2:0] REG_WINLO   = 3'd4;
    localparam logic [2:0] REG_WINHI   = 3'd5;
    localparam logic [2:0] REG_IRQ     = 3'd6;
    localparam logic [2:0] REG_INVAL   = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } xl_state_e;
endpackage

// File: rtl/gax_regs.sv
module gax_regs
    import gax_pkg::*;
#(
    parameter int N_CLIENTS = 4,
    parameter int CLW       = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_addr,
    input  logic [ADDR_W-1:0]     cfg_wdata,
    input  logic                  fault_evt,
    input  logic [ADDR_W-1:0]     fault_va_in,
    input  logic [CLW-1:0]        fault_cl_in,
    output logic                  xl_en,
    output logic [N_CLIENTS-1:0]  cl_xlate,
    output logic [RGN_W-1:0]      regions,
    output logic [ADDR_W-1:0]     pt_base,
    output logic [ADDR_W-1:ERR_ALIGN] err_hi,
    output logic [VPN_W-1:0]      win_lo,
    output logic [VPN_W-1:0]      win_hi,
    output logic                  inval,
    output logic                  fault_pending,
    output logic [ADDR_W-1:0]     fault_va,
    output logic [CLW-1:0]        fault_client,
    output logic                  irq
);
    logic irq_mask;
    logic clr_fault;

    assign inval     = cfg_we && (cfg_addr == REG_INVAL) && cfg_wdata[0];
    assign clr_fault = cfg_we && (cfg_addr == REG_IRQ) && cfg_wdata[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xl_en    <= 1'b0;
            cl_xlate <= '0;
            regions  <= '1;
            pt_base  <= '0;
            err_hi   <= '0;
            win_lo   <= '0;
            win_hi   <= '1;
            irq_mask <= 1'b0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                REG_CTRL: begin
                    xl_en    <= cfg_wdata[0];
                    cl_xlate <= cfg_wdata[8 +: N_CLIENTS];
                end
                REG_REGIONS: regions  <= cfg_wdata[RGN_W-1:0];
                REG_PTBASE:  pt_base  <= cfg_wdata;
                REG_ERRADDR: err_hi   <= cfg_wdata[ADDR_W-1:ERR_ALIGN];
                REG_WINLO:   win_lo   <= cfg_wdata[ADDR_W-1:PAGE_SHIFT];
                REG_WINHI:   win_hi   <= cfg_wdata[ADDR_W-1:PAGE_SHIFT];
                REG_IRQ:     irq_mask <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

    // fault record: clear wins over a simultaneous new fault
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_pending <= 1'b0;
            fault_va      <= '0;
            fault_client  <= '0;
        end else if (clr_fault) begin
            fault_pending <= 1'b0;
        end else if (fault_evt && !fault_pending) begin
            fault_pending <= 1'b1;
            fault_va      <= fault_va_in;
            fault_client  <= fault_cl_in;
        end
    end

    assign irq = fault_pending && irq_mask;
endmodule

// File: rtl/gax_tlb.sv
module gax_tlb
    import gax_pkg::*;
#(
    parameter int LINES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              hit,
    output logic [ADDR_W-1:0] hit_pte,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ADDR_W-1:0] fill_pte,
    input  logic              inval
);
    localparam int PW = (LINES > 1) ? $clog2(LINES) : 1;

    logic [LINES-1:0]  vld;
    logic [VPN_W-1:0]  tag  [LINES];
    logic [ADDR_W-1:0] data [LINES];
    logic [LINES-1:0]  match;
    logic [PW-1:0]     rr;

    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign match[g] = vld[g] && (tag[g] == lk_vpn);
    end

    always_comb begin
        hit_pte = '0;
        for (int i = 0; i < LINES; i++)
            if (match[i]) hit_pte = hit_pte | data[i];
    end
    assign hit = |match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
            rr  <= '0;
            for (int i = 0; i < LINES; i++) begin
                tag[i]  <= '0;
                data[i] <= '0;
            end
        end else begin
            if (fill_en) begin
                vld[rr]  <= 1'b1;
                tag[rr]  <= fill_vpn;
                data[rr] <= fill_pte;
                rr       <= (rr == PW'(LINES - 1)) ? '0 : rr + 1'b1;
            end
            if (inval) vld <= '0;
        end
    end
endmodule

// File: rtl/gax_eval.sv
module gax_eval
    import gax_pkg::*;
(
    input  logic                       translate,
    input  logic                       force_fault,
    input  logic                       is_write,
    input  logic [ADDR_W-1:0]          va,
    input  logic [ADDR_W-1:0]          pte,
    input  logic [VPN_W-1:0]           win_lo,
    input  logic [VPN_W-1:0]           win_hi,
    input  logic [ADDR_W-1:ERR_ALIGN]  err_hi,
    output logic [ADDR_W-1:0]          pa,
    output logic                       fault
);
    logic [ADDR_W-1:0] raw_pa;
    logic              perm_ok;
    logic              in_win;

    always_comb begin
        raw_pa  = translate ? {pte[ADDR_W-1:PAGE_SHIFT], va[PAGE_SHIFT-1:0]} : va;
        perm_ok = !translate ||
                  ((pte != '0) && (is_write ? pte[0] : pte[1]));
        in_win  = (raw_pa[ADDR_W-1:PAGE_SHIFT] >= win_lo) &&
                  (raw_pa[ADDR_W-1:PAGE_SHIFT] <= win_hi);
        fault   = force_fault || !perm_ok || !in_win;
        pa      = fault ? {err_hi, {ERR_ALIGN{1'b0}}} : raw_pa;
    end
endmodule

// File: rtl/gpu_addr_xlate.sv
module gpu_addr_xlate
    import gax_pkg::*;
#(
    parameter int N_CLIENTS = 4,
    parameter int TLB_LINES = 4,
    parameter int CLW       = (N_CLIENTS > 1) ? $clog2(N_CLIENTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CLW-1:0]    req_client,
    input  logic [31:0]       req_va,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic [31:0]       rsp_pa,
    output logic              rsp_fault,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    output logic              irq,
    output logic [31:0]       fault_va,
    output logic [CLW-1:0]    fault_client
);
    xl_state_e state, nxt;

    logic                      xl_en;
    logic [N_CLIENTS-1:0]      cl_xlate;
    logic [RGN_W-1:0]          regions;
    logic [ADDR_W-1:0]         pt_base;
    logic [ADDR_W-1:ERR_ALIGN] err_hi;
    logic [VPN_W-1:0]          win_lo, win_hi;
    logic                      inval;
    logic                      fault_pending;

    logic [ADDR_W-1:0] held_va;
    logic [CLW-1:0]    held_cl;
    logic              held_wr;
    logic              drop_fill;

    logic              acc, xl_now, in_range, need_fetch, rsp_fire;
    logic [ADDR_W-1:0] req_off, held_off;
    logic              tlb_hit;
    logic [ADDR_W-1:0] tlb_pte;
    logic              fill_en;

    logic              in_wait;
    logic              ev_translate, ev_force, ev_wr, ev_fault;
    logic [ADDR_W-1:0] ev_va, ev_pte, ev_pa;
    logic [CLW-1:0]    ev_cl;

    gax_regs #(.N_CLIENTS(N_CLIENTS), .CLW(CLW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .fault_evt    (rsp_fire && ev_fault),
        .fault_va_in  (ev_va),
        .fault_cl_in  (ev_cl),
        .xl_en        (xl_en),
        .cl_xlate     (cl_xlate),
        .regions      (regions),
        .pt_base      (pt_base),
        .err_hi       (err_hi),
        .win_lo       (win_lo),
        .win_hi       (win_hi),
        .inval        (inval),
        .fault_pending(fault_pending),
        .fault_va     (fault_va),
        .fault_client (fault_client),
        .irq          (irq)
    );

    // request classification in IDLE
    assign acc      = req_valid && req_ready;
    assign xl_now   = xl_en && cl_xlate[req_client];
    assign req_off  = req_va - VA_BASE;
    assign in_range = (req_va >= VA_BASE) &&
                      (req_off[ADDR_W-1:REGION_SHIFT] <
                       {{(ADDR_W-REGION_SHIFT-RGN_W){1'b0}}, regions});

    gax_tlb #(.LINES(TLB_LINES)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (req_va[ADDR_W-1:PAGE_SHIFT]),
        .hit      (tlb_hit),
        .hit_pte  (tlb_pte),
        .fill_en  (fill_en),
        .fill_vpn (held_va[ADDR_W-1:PAGE_SHIFT]),
        .fill_pte (mem_rdata),
        .inval    (inval)
    );

    assign need_fetch = acc && xl_now && in_range && !tlb_hit;

    // evaluation source: live request in IDLE, held request with table data in WAIT
    assign in_wait      = (state == ST_WAIT);
    assign ev_translate = in_wait ? 1'b1      : xl_now;
    assign ev_force     = in_wait ? 1'b0      : (xl_now && !in_range);
    assign ev_va        = in_wait ? held_va   : req_va;
    assign ev_wr        = in_wait ? held_wr   : req_write;
    assign ev_cl        = in_wait ? held_cl   : req_client;
    assign ev_pte       = in_wait ? mem_rdata : tlb_pte;

    gax_eval u_eval (
        .translate  (ev_translate),
        .force_fault(ev_force),
        .is_write   (ev_wr),
        .va         (ev_va),
        .pte        (ev_pte),
        .win_lo     (win_lo),
        .win_hi     (win_hi),
        .err_hi     (err_hi),
        .pa         (ev_pa),
        .fault      (ev_fault)
    );

    assign rsp_fire = (acc && !need_fetch) || (in_wait && mem_rvalid);
    assign fill_en  = in_wait && mem_rvalid && (mem_rdata != '0) && !drop_fill;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions: miss (IDLE->FETCH), issue (FETCH->WAIT), return (WAIT->IDLE)
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (need_fetch) nxt = ST_FETCH;
            ST_FETCH: nxt = ST_WAIT;
            ST_WAIT:  if (mem_rvalid) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_FETCH: mem_req   = 1'b1;
            ST_WAIT:  ;
            default:  ;
        endcase
    end

    assign held_off = held_va - VA_BASE;
    assign mem_addr = pt_base + {{(PAGE_SHIFT-2){1'b0}}, held_off[ADDR_W-1:PAGE_SHIFT], 2'b00};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_va   <= '0;
            held_cl   <= '0;
            held_wr   <= 1'b0;
            drop_fill <= 1'b0;
        end else begin
            if (acc) begin
                held_va <= req_va;
                held_cl <= req_client;
                held_wr <= req_write;
            end
            if (state == ST_IDLE) drop_fill <= 1'b0;
            else if (inval)       drop_fill <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_pa    <= '0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_valid <= rsp_fire;
            if (rsp_fire) begin
                rsp_pa    <= ev_pa;
                rsp_fault <= ev_fault;
            end
        end
    end
endmodule

// File: rtl/gax_chk.sv
module gax_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       rsp_fault,
    input logic [4:0] rsp_pa_lo,
    input logic       mem_req,
    input logic       mem_rvalid,
    input logic [31:0] fault_va,
    input logic       fault_pending,
    input logic       irq
);
    // R3
    fetch_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);
    // R3
    fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R9
    redirect_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_pa_lo == 5'd0));
    // R11
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fault_pending) && fault_pending) |-> $stable(fault_va));
    // R12
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> fault_pending);
    // R6
    rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rvalid)));
endmodule

bind gpu_addr_xlate gax_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_pa_lo    (rsp_pa[4:0]),
    .mem_req      (mem_req),
    .mem_rvalid   (mem_rvalid),
    .fault_va     (fault_va),
    .fault_pending(fault_pending),
    .irq          (irq)
);

// File: tb/gpu_addr_xlate_tb.sv
`timescale 1ns/1ps
module gpu_addr_xlate_tb;
    localparam logic [31:0] PT  = 32'h0008_0000;
    localparam logic [31:0] ERR = 32'h0000_7FE0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_client = '0;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid, rsp_fault, mem_req, irq;
    logic [31:0] rsp_pa, mem_addr, fault_va;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  fault_client;

    int checks = 0, fails = 0, fetch_cnt = 0;
    logic [31:0] last_addr = '0;

    always #2 clk = ~clk;

    gpu_addr_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_client(req_client), .req_va(req_va), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .irq(irq), .fault_va(fault_va),
        .fault_client(fault_client)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pte_of(input logic [31:0] a);
        logic [31:0] idx = (a - PT) >> 2;
        case (idx)
            32'd0:   return 32'h2000_0003;
            32'd1:   return 32'h2000_5002;
            32'd2:   return 32'h2001_0001;
            32'd4, 32'd5, 32'd6, 32'd7: return 32'h3000_0003 | (idx << 12);
            default: return 32'h0;
        endcase
    endfunction

    // table memory: answers one cycle after the request
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                fetch_cnt++;
                last_addr = mem_addr;
                chk(!req_ready, "R3 ready low while fetch outstanding", {31'd0, req_ready}, 32'd0);
                @(posedge clk); #1;
                mem_rvalid = 1'b1;
                mem_rdata  = pte_of(mem_addr);
                @(posedge clk); #1;
                mem_rvalid = 1'b0;
            end
        end
    end

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_req(input logic [1:0] cl, input logic [31:0] va, input logic wr,
                          output logic [31:0] pa, output logic f, output int lat, output int fd);
        int f0 = fetch_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_client = cl; req_va = va; req_write = wr;
        @(posedge clk); #1;
        req_valid = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!rsp_valid && lat < 20);
        pa = rsp_pa; f = rsp_fault; fd = fetch_cnt - f0;
    endtask

    typedef struct packed {
        logic [1:0]  cl;
        logic [31:0] va;
        logic        wr;
        logic [31:0] pa;
        logic        flt;
        logic [2:0]  lat;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VT [NV] = '{
        '{2'd0, 32'h0100_0123, 1'b0, 32'h2000_0123, 1'b0, 3'd3}, // R3 R4 miss fills line 0
        '{2'd0, 32'h0100_0456, 1'b1, 32'h2000_0456, 1'b0, 3'd1}, // R6 hit
        '{2'd1, 32'h0100_1010, 1'b0, 32'h2000_5010, 1'b0, 3'd3}, // R4 read-only page, line 1
        '{2'd1, 32'h0100_1010, 1'b1, ERR,           1'b1, 3'd1}, // R4 R9 write denied, first fault
        '{2'd2, 32'h0100_2008, 1'b1, 32'h2001_0008, 1'b0, 3'd3}, // R4 write-only page, line 2
        '{2'd2, 32'h0100_2008, 1'b0, ERR,           1'b1, 3'd1}, // R4 read denied
        '{2'd0, 32'h0100_3000, 1'b0, ERR,           1'b1, 3'd3}, // R5 empty entry
        '{2'd0, 32'h0100_3000, 1'b0, ERR,           1'b1, 3'd3}, // R5 not cached, refetched
        '{2'd3, 32'h0100_3000, 1'b0, 32'h0100_3000, 1'b0, 3'd1}, // R1 client bypass
        '{2'd0, 32'h00FF_FFFC, 1'b0, ERR,           1'b1, 3'd1}, // R2 below base
        '{2'd0, 32'h10FF_0000, 1'b0, ERR,           1'b1, 3'd1}, // R2 at limit
        '{2'd0, 32'h10FE_F004, 1'b0, ERR,           1'b1, 3'd3}, // R2 last page in range fetched
        '{2'd0, 32'h0100_4ABC, 1'b0, 32'h3000_4ABC, 1'b0, 3'd3}, // R7 line 3
        '{2'd0, 32'h0100_5000, 1'b1, 32'h3000_5000, 1'b0, 3'd3}, // R7 evicts line 0
        '{2'd0, 32'h0100_0000, 1'b0, 32'h2000_0000, 1'b0, 3'd3}, // R7 evicts line 1
        '{2'd2, 32'h0100_2FFF, 1'b1, 32'h2001_0FFF, 1'b0, 3'd1}, // R7 line 2 survived
        '{2'd1, 32'h0100_1000, 1'b0, 32'h2000_5000, 1'b0, 3'd3}, // R7 page 1 was evicted
        '{2'd0, 32'h0100_4000, 1'b1, 32'h3000_4000, 1'b0, 3'd1}  // R7 line 3 survived
    };

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] pa;
        logic f;
        int lat, fd;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(req_ready == 1'b1, "R13 req_ready", {31'd0, req_ready}, 32'd1);
        chk(rsp_valid == 1'b0, "R13 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk(mem_req == 1'b0,   "R13 mem_req", {31'd0, mem_req}, 32'd0);
        chk(irq == 1'b0,       "R13 irq", {31'd0, irq}, 32'd0);
        chk(fault_va == 32'd0, "R13 fault_va", fault_va, 32'd0);

        // R1 R10 translation off after reset; reset window covers the top page
        do_req(2'd0, 32'hFFFF_F800, 1'b0, pa, f, lat, fd);
        chk(pa == 32'hFFFF_F800 && !f, "R10 reset window top page", pa, 32'hFFFF_F800);
        chk(lat == 1 && fd == 0, "R1 bypass latency", lat, 1);

        cfg_write(3'd2, PT);
        cfg_write(3'd3, 32'h0000_7FFF);
        cfg_write(3'd0, 32'h0000_0701);

        for (int i = 0; i < NV; i++) begin
            do_req(VT[i].cl, VT[i].va, VT[i].wr, pa, f, lat, fd);
            chk(pa == VT[i].pa, $sformatf("R4 vec%0d address", i), pa, VT[i].pa);
            chk(f == VT[i].flt, $sformatf("R9 vec%0d fault flag", i), {31'd0, f}, {31'd0, VT[i].flt});
            chk(lat == int'(VT[i].lat), $sformatf("%s vec%0d latency", (VT[i].lat == 3'd3) ? "R3" : "R6", i),
                lat, {29'd0, VT[i].lat});
            chk(fd == ((VT[i].lat == 3'd3) ? 1 : 0), $sformatf("R6 vec%0d table reads", i),
                fd, (VT[i].lat == 3'd3) ? 32'd1 : 32'd0);
            if (VT[i].lat == 3'd3)
                chk(last_addr == PT + (((VT[i].va - 32'h0100_0000) >> 12) << 2),
                    $sformatf("R3 vec%0d table address", i), last_addr,
                    PT + (((VT[i].va - 32'h0100_0000) >> 12) << 2));
        end

        // R11 first fault held; R12 mask gates irq
        chk(fault_va == 32'h0100_1010, "R11 recorded VA", fault_va, 32'h0100_1010);
        chk(fault_client == 2'd1, "R11 recorded client", {30'd0, fault_client}, 32'd1);
        chk(irq == 1'b0, "R12 irq masked", {31'd0, irq}, 32'd0);
        cfg_write(3'd6, 32'h1);
        chk(irq == 1'b1, "R12 irq unmasked", {31'd0, irq}, 32'd1);
        cfg_write(3'd6, 32'h3);
        chk(irq == 1'b0, "R11 clear drops record", {31'd0, irq}, 32'd0);
        do_req(2'd0, 32'h00FF_FFF0, 1'b0, pa, f, lat, fd);
        chk(fault_va == 32'h00FF_FFF0 && fault_client == 2'd0, "R11 new record after clear",
            fault_va, 32'h00FF_FFF0);
        chk(irq == 1'b1, "R12 irq on new fault", {31'd0, irq}, 32'd1);
        cfg_write(3'd6, 32'h2);
        chk(irq == 1'b0, "R12 irq after clear", {31'd0, irq}, 32'd0);

        // R10 narrow protection window to page 0x20000
        cfg_write(3'd4, 32'h2000_0000);
        cfg_write(3'd5, 32'h2000_0000);
        do_req(2'd0, 32'h0100_0010, 1'b0, pa, f, lat, fd);
        chk(pa == 32'h2000_0010 && !f, "R10 inside window", pa, 32'h2000_0010);
        do_req(2'd0, 32'h0100_4000, 1'b0, pa, f, lat, fd);
        chk(pa == ERR && f, "R10 translated page outside window", pa, ERR);
        do_req(2'd3, 32'h0100_0000, 1'b0, pa, f, lat, fd);
        chk(pa == ERR && f, "R10 bypass page outside window", pa, ERR);
        cfg_write(3'd4, 32'h0);
        cfg_write(3'd5, 32'hFFFF_F000);

        // R1 global enable off
        cfg_write(3'd0, 32'h0000_0700);
        do_req(2'd0, 32'h0100_0123, 1'b0, pa, f, lat, fd);
        chk(pa == 32'h0100_0123 && !f && lat == 1, "R1 global disable bypass", pa, 32'h0100_0123);
        cfg_write(3'd0, 32'h0000_0701);

        // R8 invalidate-all then refetch
        cfg_write(3'd7, 32'h1);
        do_req(2'd0, 32'h0100_4000, 1'b0, pa, f, lat, fd);
        chk(lat == 3 && pa == 32'h3000_4000, "R8 refetch after invalidate", lat, 3);

        // R8 invalidate during an outstanding fetch
        fork
            do_req(2'd0, 32'h0100_6000, 1'b0, pa, f, lat, fd);
            begin
                repeat (2) @(posedge clk);
                cfg_write(3'd7, 32'h1);
            end
        join
        chk(pa == 32'h3000_6000 && lat == 3, "R8 in-flight access result", pa, 32'h3000_6000);
        do_req(2'd0, 32'h0100_6000, 1'b0, pa, f, lat, fd);
        chk(lat == 3, "R8 in-flight entry not cached", lat, 3);
        do_req(2'd0, 32'h0100_6000, 1'b0, pa, f, lat, fd);
        chk(lat == 1 && pa == 32'h3000_6000, "R6 cached after normal fill", lat, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule